// File: doc/BRIEF.md
# Clock Ratio and Frame Sync Monitor

This block watches the clocks that feed a multichannel audio converter core. It counts system-clock cycles between rising edges of the frame (sample-rate) clock to find which integer ratio links the two clocks. Only six ratios are supported: 128, 192, 256, 384, 512 and 768 cycles per frame. A ratio is taken only after two frames in a row agree on it. Once a ratio is held, a reference frame counter runs freely in the system-clock domain. At each real frame edge the monitor measures how far that edge sits from the reference, in bit-clock periods.

When the frame edge wanders too far, or frame edges stop arriving, the monitor drops back to hunting for a ratio. While it has no lock it raises a clock-fault flag, and it tells the signal path to hold its outputs at midscale. After a new lock it keeps the midscale hold for one more frame, and releases it only if that frame edge lands close to the reference. The bit clock and frame clock are assumed to be synchronous to the system clock and are sampled on it directly.

Top module: `clk_sync_mon`

## Requirements
- R1: While reset is high and in the cycle after it, the fault flag is 1, midscale force is 1 and the ratio code is 7.
- R2: The ratio code is 0, 1, 2, 3, 4 or 5 for a held ratio of 128, 192, 256, 384, 512 or 768 cycles per frame. It reads 7 whenever the fault flag is set, and it does not change while the fault flag stays low.
- R3: A ratio is accepted at a frame edge only when two conditions hold. The period just ended must equal a supported ratio exactly. The period before it must be within plus or minus one cycle of it.
- R4: A frame period that matches no supported ratio (for example 320) is never accepted, so the fault flag stays at 1 and the code stays at 7.
- R5: On acceptance the fault flag falls but midscale force stays at 1. Midscale force falls at the next frame edge if that edge is within the drift limit. Midscale force never falls in a cycle in which, or just after, the fault flag is 1.
- R6: While a ratio is held, a frame edge up to 6 bit-clock periods early or late of the reference causes no fault. One frame carries 64 bit clocks.
- R7: While a ratio is held, a frame edge 7 or more bit-clock periods early or late sets the fault flag and midscale force in the next cycle. The code then reads 7.
- R8: While a ratio is held, more than 1024 system clocks without a frame edge set the fault flag.
- R9: After a drift fault, the period that ends at the offending edge is discarded. Lock returns only at the second frame edge after it, and midscale force is released one frame later.
- R10: The fault flag set always implies midscale force set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_i | input | 1 | Bit clock, sampled on clk |
| fclk_i | input | 1 | Frame clock, rising edge marks frame start |
| ratio_code_o | output | 3 | Held ratio code 0 to 5, 7 when none |
| clk_fault_o | output | 1 | Clock fault, high while no ratio is held |
| force_mid_o | output | 1 | Hold outputs at midscale |

## Verification
A single frame edge can end a drift check and also supply a period to the ratio qualifier. When the drift check fails, the same edge clears the qualifier's stored period. Directed stimulus delays one frame by 7 bit periods after lock. The bench then confirms that the fault appears at once, and that lock is withheld at the following edge even though that period is a clean 256. Lock must return only at the edge after that. A second overlap comes from boundary frames shifted by exactly 6 and exactly 7 bit periods, early and late. These separate the tolerated drift from the drift that restarts acquisition.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOCK = 2'd2
    } sync_st_e;

    localparam logic [2:0] CODE_BAD = 3'd7;

    // Supported cycles-per-frame ratios, ascending code order.
    function automatic logic [2:0] ratio_code(input logic [15:0] n);
        case (n)
            16'd128: return 3'd0;
            16'd192: return 3'd1;
            16'd256: return 3'd2;
            16'd384: return 3'd3;
            16'd512: return 3'd4;
            16'd768: return 3'd5;
            default: return CODE_BAD;
        endcase
    endfunction

    function automatic logic [15:0] ratio_len(input logic [2:0] c);
        case (c)
            3'd0:    return 16'd128;
            3'd1:    return 16'd192;
            3'd2:    return 16'd256;
            3'd3:    return 16'd384;
            3'd4:    return 16'd512;
            3'd5:    return 16'd768;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/frm_period_ctr.sv
module frm_period_ctr #(
    parameter int MISS_LIMIT = 1024,
    parameter int CW         = $clog2(MISS_LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fclk_i,
    output logic          edge_o,
    output logic [CW-1:0] period_o,
    output logic          miss_o
);
    localparam logic [CW-1:0] SAT = CW'(MISS_LIMIT + 1);

    logic          fclk_q;
    logic [CW-1:0] cnt;

    assign edge_o   = fclk_i & ~fclk_q;
    assign period_o = cnt;
    assign miss_o   = (cnt == SAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            fclk_q <= 1'b0;
            cnt    <= SAT;
        end else begin
            fclk_q <= fclk_i;
            if (edge_o)
                cnt <= CW'(1);
            else if (cnt < SAT)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ratio_qual.sv
module ratio_qual
    import clkmon_pkg::*;
#(
    parameter int MISS_LIMIT = 1024,
    parameter int CW         = $clog2(MISS_LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_i,
    input  logic [CW-1:0] period_i,
    input  logic          clr_i,
    output logic          acq_o,
    output logic [2:0]    code_o
);
    localparam logic [CW-1:0] SAT = CW'(MISS_LIMIT + 1);

    logic [CW-1:0] prev;
    logic [CW-1:0] diff;

    assign code_o = ratio_code(16'(period_i));
    assign diff   = (prev > period_i) ? (prev - period_i) : (period_i - prev);
    assign acq_o  = edge_i && (code_o != CODE_BAD) && (diff <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            prev <= SAT;
        else if (clr_i)
            prev <= SAT;
        else if (edge_i)
            prev <= period_i;
    end
endmodule

// File: rtl/phase_trk.sv
module phase_trk #(
    parameter int CW        = 11,
    parameter int BITS      = 64,
    parameter int DRIFT_MAX = 6,
    parameter int PW        = $clog2(BITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk_i,
    input  logic          edge_i,
    input  logic          align_i,
    input  logic [CW-1:0] lock_len_i,
    output logic          drift_bad_o
);
    logic [CW-1:0] ref_cnt;
    logic          bclk_q;
    logic          brise;
    logic          wrap;
    logic [PW-1:0] bpos;
    logic [PW-1:0] pos;
    logic [PW-1:0] drift;

    assign brise = bclk_i & ~bclk_q;
    assign wrap  = (ref_cnt == lock_len_i);
    assign pos   = wrap ? '0 : bpos;
    assign drift = (pos <= PW'(BITS / 2)) ? pos : (PW'(BITS) - pos);
    assign drift_bad_o = edge_i && (drift > PW'(DRIFT_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt <= '0;
            bclk_q  <= 1'b0;
            bpos    <= '0;
        end else begin
            bclk_q <= bclk_i;
            if (align_i || wrap)
                ref_cnt <= CW'(1);
            else
                ref_cnt <= ref_cnt + 1'b1;
            if (align_i || wrap)
                bpos <= brise ? PW'(1) : '0;
            else if (brise && bpos < PW'(BITS))
                bpos <= bpos + 1'b1;
        end
    end
endmodule

// File: rtl/clk_sync_mon.sv
module clk_sync_mon
    import clkmon_pkg::*;
#(
    parameter int MISS_LIMIT = 1024,
    parameter int BITS       = 64,
    parameter int DRIFT_MAX  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bclk_i,
    input  logic       fclk_i,
    output logic [2:0] ratio_code_o,
    output logic       clk_fault_o,
    output logic       force_mid_o
);
    localparam int CW = $clog2(MISS_LIMIT + 2);

    sync_st_e      state;
    logic [2:0]    lock_code;
    logic          f_edge;
    logic [CW-1:0] period;
    logic          miss;
    logic          acq;
    logic [2:0]    cand_code;
    logic          drift_bad;
    logic          held;
    logic          lose;
    logic          align;
    logic [CW-1:0] lock_len;

    assign held     = (state != ST_HUNT);
    assign lose     = held && (miss || drift_bad);
    assign align    = (state == ST_HUNT) && acq;
    assign lock_len = CW'(ratio_len(lock_code));

    frm_period_ctr #(.MISS_LIMIT(MISS_LIMIT), .CW(CW)) u_period (
        .clk(clk), .rst(rst), .fclk_i(fclk_i),
        .edge_o(f_edge), .period_o(period), .miss_o(miss)
    );

    ratio_qual #(.MISS_LIMIT(MISS_LIMIT), .CW(CW)) u_qual (
        .clk(clk), .rst(rst), .edge_i(f_edge), .period_i(period),
        .clr_i(lose), .acq_o(acq), .code_o(cand_code)
    );

    phase_trk #(.CW(CW), .BITS(BITS), .DRIFT_MAX(DRIFT_MAX)) u_phase (
        .clk(clk), .rst(rst), .bclk_i(bclk_i), .edge_i(f_edge),
        .align_i(align), .lock_len_i(lock_len), .drift_bad_o(drift_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            lock_code <= CODE_BAD;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (acq) begin
                        state     <= ST_HOLD;
                        lock_code <= cand_code;
                    end
                end
                default: begin
                    if (lose)
                        state <= ST_HUNT;
                    else if (f_edge && state == ST_HOLD)
                        state <= ST_LOCK;
                end
            endcase
        end
    end

    assign clk_fault_o  = (state == ST_HUNT);
    assign force_mid_o  = (state != ST_LOCK);
    assign ratio_code_o = (state == ST_HUNT) ? CODE_BAD : lock_code;
endmodule

// File: rtl/clk_sync_mon_chk.sv
module clk_sync_mon_chk (
    input logic       clk,
    input logic       rst,
    input logic       fault_i,
    input logic       mid_i,
    input logic [2:0] code_i
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (fault_i && mid_i && code_i == 3'd7));

    assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
        !fault_i |-> (code_i <= 3'd5));

    assert_code_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (!fault_i && $past(!fault_i)) |-> $stable(code_i));

    assert_lock_holds_mid_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_i) |-> mid_i);

    assert_release_after_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mid_i) |-> (!fault_i && $past(!fault_i)));

    assert_fault_forces_mid_R10: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> mid_i);
endmodule

bind clk_sync_mon clk_sync_mon_chk u_chk (
    .clk(clk), .rst(rst), .fault_i(clk_fault_o),
    .mid_i(force_mid_o), .code_i(ratio_code_o)
);

// File: tb/clk_sync_mon_bench.sv
module clk_sync_mon_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bck = 1'b0;
    logic       fck = 1'b0;
    logic [2:0] code;
    logic       fault;
    logic       mid;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #4 clk = ~clk;

    clk_sync_mon u_clk_sync_mon (
        .clk(clk), .rst(rst), .bclk_i(bck), .fclk_i(fck),
        .ratio_code_o(code), .clk_fault_o(fault), .force_mid_o(mid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic f, input logic b);
        @(negedge clk);
        fck = f;
        bck = b;
    endtask

    // One frame of len cycles; bit clock rises every bp cycles from the start.
    task automatic frame(input int len, input int bp);
        for (int i = 0; i < len; i++)
            cyc(i < len / 2, (i % bp) < bp / 2);
    endtask

    task automatic gap(input int k, input int bp);
        for (int i = 0; i < k * bp; i++)
            cyc(1'b0, (i % bp) < bp / 2);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fck = 1'b0;
        bck = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic lock_at(input int bp);
        do_reset();
        repeat (4) frame(64 * bp, bp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 fault in reset", fault, 1);
        chk("R1 mid in reset", mid, 1);
        chk("R1 code in reset", code, 7);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fault after reset", fault, 1);
        chk("R1 code after reset", code, 7);
    endtask

    task automatic t_ratios();
        int rat[6] = '{128, 192, 256, 384, 512, 768};
        for (int c = 0; c < 6; c++) begin
            do_reset();
            repeat (2) frame(rat[c], rat[c] / 64);
            chk("R3 no lock after one period", fault, 1);
            frame(rat[c], rat[c] / 64);
            chk("R5 fault low at lock", fault, 0);
            chk("R5 mid held during first frame", mid, 1);
            chk("R2 code at lock", code, c);
            frame(rat[c], rat[c] / 64);
            chk("R5 mid released", mid, 0);
            chk("R2 code locked", code, c);
        end
    endtask

    task automatic t_tolerance();
        do_reset();
        frame(257, 4);
        frame(256, 4);
        frame(256, 4);
        chk("R3 accept 257 then 256", fault, 0);
        chk("R3 code 256", code, 2);
        do_reset();
        frame(258, 4);
        frame(256, 4);
        frame(256, 4);
        chk("R3 reject 258 then 256", fault, 1);
        frame(256, 4);
        chk("R3 accept after two 256", fault, 0);
        do_reset();
        frame(256, 4);
        frame(257, 4);
        frame(256, 4);
        chk("R3 reject inexact 257 period", fault, 1);
    endtask

    task automatic t_invalid();
        do_reset();
        repeat (5) frame(320, 5);
        chk("R4 fault on 320", fault, 1);
        chk("R4 code on 320", code, 7);
        chk("R4 mid on 320", mid, 1);
    endtask

    task automatic t_drift_ok();
        lock_at(4);
        gap(6, 4);
        repeat (2) frame(256, 4);
        chk("R6 late 6 no fault", fault, 0);
        chk("R6 late 6 mid low", mid, 0);
        lock_at(4);
        frame(256 - 24, 4);
        repeat (2) frame(256, 4);
        chk("R6 early 6 no fault", fault, 0);
        chk("R6 early 6 mid low", mid, 0);
    endtask

    task automatic t_drift_bad_resync();
        lock_at(4);
        chk("R7 locked before", mid, 0);
        gap(7, 4);
        frame(256, 4);
        chk("R7 late 7 fault", fault, 1);
        chk("R7 late 7 mid", mid, 1);
        chk("R7 late 7 code", code, 7);
        frame(256, 4);
        chk("R9 no lock one edge after fault", fault, 1);
        frame(256, 4);
        chk("R9 relock second edge", fault, 0);
        chk("R9 mid held after relock", mid, 1);
        frame(256, 4);
        chk("R9 mid released", mid, 0);
        lock_at(4);
        frame(256 - 28, 4);
        frame(256, 4);
        chk("R7 early 7 fault", fault, 1);
    endtask

    task automatic t_timeout();
        lock_at(12);
        chk("R8 locked at 768", mid, 0);
        repeat (200) cyc(1'b0, 1'b0);
        chk("R8 no fault before limit", fault, 0);
        repeat (100) cyc(1'b0, 1'b0);
        chk("R8 fault after missing frame", fault, 1);
        chk("R10 mid with fault", mid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ratios();
        t_tolerance();
        t_invalid();
        t_drift_ok();
        t_drift_bad_resync();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule